// File: doc/BRIEF.md
# Packed Fuse Map Parser

The parser turns a packed physical fuse image into one logical byte window. The image is held in an external byte memory that the parser reads one byte at a time. The image is a chain of variable-length records. Each record opens with a header that names a page, a block offset and a four-bit mask. Each mask bit that is zero announces one 2-byte data word that follows the header. The parser writes only the bytes that fall into the requested page and byte range. Those bytes go, relative to the window start, through a byte write port into a logical map owned by the caller.

A start pulse latches the configuration: mode, target page, window offset and length, the size of the reserved region at the head of the image, and the image length. The parser first writes 0xFF to every byte of the window. It then walks the records. When parsing ends, it raises `done` for one cycle, and `err` then tells a clean end from a malformed image. A second, compact mode uses 2-byte headers that carry no page field.

Top module: `fuse_map_parser`

## Requirements
- R1: While reset is held and directly after it, `done`, `err`, `phy_rd_en` and `log_wr_en` are all low.
- R2: After a start, every window byte 0 to `cfg_size`-1 is written with 0xFF before any record byte is written, so a byte no record reaches ends as 0xFF.
- R3: In normal mode (`cfg_alt`=0) a header is three bytes taken most significant first into 24 bits. Bits 19:17 hold the page, bits 16:4 the block offset and bits 3:0 the mask. Only records whose page equals `cfg_page` are written.
- R4: In compact mode (`cfg_alt`=1) a header is two bytes taken most significant first. Bits 11:4 hold the block offset and bits 3:0 the mask. Every record counts as being on the target page.
- R5: Mask bit i at 0 means word i is present and takes the next two image bytes, lower address first. At 1 the word is absent and takes no bytes. Words are handled in the order 0, 1, 2, 3. Word i lands at logical index offset×8 + 2i: its first byte goes to that even index and its second to the next one.
- R6: A word is written when its logical index lies in [offset rounded down to even, offset+size rounded up to even). When the window starts on an odd offset, only the second byte of the leading word is written. When it ends on an odd byte, only the first byte of the trailing word is written. Write addresses are the logical index minus `cfg_offset`.
- R7: A present word on another page, or one outside the window, causes no write but still advances the image position by two bytes.
- R8: Parsing ends cleanly, with `done` for one cycle and `err`=0, in any of three cases: a header byte reads 0xFF, a header byte would lie at or past `cfg_phy_size`, or the position reaches `cfg_phy_size` between records. No read is ever issued at or past `cfg_phy_size`.
- R9: A header whose block offset is at or above MAX_LOG_BYTES/8 ends parsing with `err`=1 and writes nothing for that record.
- R10: A present word that starts at or past position `cfg_phy_size`-1 ends parsing with `err`=1.
- R11: The first header is read at byte `cfg_skip`. If `cfg_skip` is at or past `cfg_phy_size`, only the 0xFF fill takes place.
- R12: When two records cover the same logical byte, the one later in the image determines the final value.
- R13: A start pulse while a parse is running is ignored, and the latched configuration stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a parse; sampled only while idle |
| cfg_alt | input | 1 | 1 selects 2-byte headers without page field |
| cfg_page | input | 3 | Target page (normal mode) |
| cfg_offset | input | LOG_AW+1 | First logical byte of the window |
| cfg_size | input | LOG_AW+1 | Window length in bytes, at least 1 |
| cfg_skip | input | PHY_AW | Reserved bytes before the first header |
| cfg_phy_size | input | PHY_AW+1 | Length of the physical image in bytes |
| phy_rd_en | output | 1 | Image read request |
| phy_rd_addr | output | PHY_AW | Image byte address |
| phy_rd_data | input | 8 | Image byte, valid one cycle after the request |
| log_wr_en | output | 1 | Logical map byte write |
| log_wr_addr | output | LOG_AW | Byte address relative to the window start |
| log_wr_data | output | 8 | Byte to write |
| done | output | 1 | One-cycle pulse at the end of a parse |
| err | output | 1 | Format error flag, valid with done, held until next start |

## Verification
The images mix present and absent words, foreign-page records and repeated blocks. This shows whether the mask controls how many bytes a record consumes, and whether skipped words still advance the position. The same image is parsed through an even window and through an odd-edged one, which separates the partial writes at the leading and trailing edges from full word writes. The runs that end by a 0xFF byte, by the image length between records and by a header that straddles the end have to finish cleanly. The runs with an oversized block offset or a truncated word have to report a fault. The bench compares every write, as it happens, against the write order predicted by the model, so a wrong order or a missing skip appears at once rather than only in the final map.

// File: rtl/fmp_pkg.sv
package fmp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILL,
        S_NEXT,
        S_HRD,
        S_HCAP,
        S_HEVAL,
        S_WORD,
        S_W0RD,
        S_W0CAP,
        S_W1RD,
        S_W1CAP,
        S_WLO,
        S_WHI,
        S_DONE
    } fmp_state_e;

    typedef struct packed {
        logic [2:0]  page;
        logic [12:0] blk;
        logic [3:0]  wen;
    } fmp_hdr_t;

    localparam logic [7:0] ERASED = 8'hFF;

    // Split a collected header into its fields for either header format.
    function automatic fmp_hdr_t fmp_decode(input logic [23:0] raw, input logic alt);
        fmp_hdr_t h;
        if (alt) begin
            h.page = 3'd0;
            h.blk  = {5'd0, raw[11:4]};
        end else begin
            h.page = raw[19:17];
            h.blk  = raw[16:4];
        end
        h.wen = raw[3:0];
        return h;
    endfunction

endpackage

// File: rtl/fmp_hdr_unit.sv
module fmp_hdr_unit
    import fmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       shift,
    input  logic [7:0] byte_in,
    input  logic       alt,
    output fmp_hdr_t   hdr
);

    logic [23:0] raw;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            raw <= '0;
        end else if (shift) begin
            raw <= {raw[15:0], byte_in};
        end
    end

    always_comb hdr = fmp_decode(raw, alt);

endmodule

// File: rtl/fmp_window.sv
module fmp_window #(
    parameter int LW = 11
) (
    input  logic [LW-1:0] off,
    input  logic [LW-1:0] size,
    input  logic [LW-1:0] lidx,
    output logic          in_win,
    output logic          wr_lo,
    output logic          wr_hi
);

    logic [LW:0] wmin;
    logic [LW:0] endp;
    logic [LW:0] wmax;
    logic [LW:0] lx;
    logic        lead;
    logic        trail;

    always_comb begin
        lx     = {1'b0, lidx};
        wmin   = {1'b0, off[LW-1:1], 1'b0};
        endp   = {1'b0, off} + {1'b0, size};
        wmax   = endp + {{LW{1'b0}}, endp[0]};
        in_win = (lx >= wmin) && (lx < wmax);
        lead   = (lx == wmin) && off[0];
        trail  = ((lx + 2'd2) == wmax) && endp[0];
        wr_lo  = !lead;
        wr_hi  = !trail;
    end

endmodule

// File: rtl/fuse_map_parser.sv
module fuse_map_parser
    import fmp_pkg::*;
#(
    parameter int PHY_AW        = 10,
    parameter int MAX_LOG_BYTES = 1024
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          cfg_alt,
    input  logic [2:0]                    cfg_page,
    input  logic [$clog2(MAX_LOG_BYTES):0] cfg_offset,
    input  logic [$clog2(MAX_LOG_BYTES):0] cfg_size,
    input  logic [PHY_AW-1:0]             cfg_skip,
    input  logic [PHY_AW:0]               cfg_phy_size,
    output logic                          phy_rd_en,
    output logic [PHY_AW-1:0]             phy_rd_addr,
    input  logic [7:0]                    phy_rd_data,
    output logic                          log_wr_en,
    output logic [$clog2(MAX_LOG_BYTES)-1:0] log_wr_addr,
    output logic [7:0]                    log_wr_data,
    output logic                          done,
    output logic                          err
);

    localparam int LOG_AW  = $clog2(MAX_LOG_BYTES);
    localparam int LW      = LOG_AW + 1;
    localparam int IW      = PHY_AW + 2;
    localparam int MAX_BLK = MAX_LOG_BYTES / 8;

    fmp_state_e     st;
    logic [IW-1:0]  idx;
    logic [1:0]     hcnt;
    logic [2:0]     widx;
    logic [LW-1:0]  fill_cnt;
    logic [7:0]     b0, b1;
    logic           err_q;

    logic           alt_q;
    logic [2:0]     page_q;
    logic [LW-1:0]  off_q, size_q;
    logic [IW-1:0]  psz;

    fmp_hdr_t       hdr;
    logic           hdr_clr, hdr_shift;
    logic [1:0]     hlast;
    logic [IW-1:0]  hpos;
    logic [LW-1:0]  lidx;
    logic           in_win, wr_lo, wr_hi, page_ok;

    assign hlast   = alt_q ? 2'd1 : 2'd2;
    assign hpos    = idx + IW'(hcnt);
    assign lidx    = {hdr.blk[LW-4:0], widx[1:0], 1'b0};
    assign page_ok = alt_q || (hdr.page == page_q);

    fmp_hdr_unit u_hdr (
        .clk     (clk),
        .rst     (rst),
        .clr     (hdr_clr),
        .shift   (hdr_shift),
        .byte_in (phy_rd_data),
        .alt     (alt_q),
        .hdr     (hdr)
    );

    fmp_window #(.LW(LW)) u_win (
        .off    (off_q),
        .size   (size_q),
        .lidx   (lidx),
        .in_win (in_win),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi)
    );

    assign hdr_clr   = (st == S_NEXT);
    assign hdr_shift = (st == S_HCAP);

    // Image read port
    always_comb begin
        phy_rd_en   = 1'b0;
        phy_rd_addr = '0;
        unique case (st)
            S_HRD: begin
                phy_rd_en   = (hpos < psz);
                phy_rd_addr = PHY_AW'(hpos);
            end
            S_W0RD: begin
                phy_rd_en   = 1'b1;
                phy_rd_addr = PHY_AW'(idx);
            end
            S_W1RD: begin
                phy_rd_en   = 1'b1;
                phy_rd_addr = PHY_AW'(idx + 1'b1);
            end
            default: ;
        endcase
    end

    // Logical write port
    always_comb begin
        log_wr_en   = 1'b0;
        log_wr_addr = '0;
        log_wr_data = ERASED;
        unique case (st)
            S_FILL: begin
                log_wr_en   = 1'b1;
                log_wr_addr = LOG_AW'(fill_cnt);
            end
            S_WLO: begin
                log_wr_en   = 1'b1;
                log_wr_addr = LOG_AW'(lidx - off_q);
                log_wr_data = b0;
            end
            S_WHI: begin
                log_wr_en   = 1'b1;
                log_wr_addr = LOG_AW'(lidx - off_q + 1'b1);
                log_wr_data = b1;
            end
            default: ;
        endcase
    end

    assign done = (st == S_DONE);
    assign err  = err_q;

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            idx      <= '0;
            hcnt     <= '0;
            widx     <= '0;
            fill_cnt <= '0;
            b0       <= '0;
            b1       <= '0;
            err_q    <= 1'b0;
            alt_q    <= 1'b0;
            page_q   <= '0;
            off_q    <= '0;
            size_q   <= '0;
            psz      <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        alt_q    <= cfg_alt;
                        page_q   <= cfg_page;
                        off_q    <= cfg_offset;
                        size_q   <= cfg_size;
                        psz      <= IW'(cfg_phy_size);
                        idx      <= IW'(cfg_skip);
                        fill_cnt <= '0;
                        err_q    <= 1'b0;
                        st       <= (cfg_size == '0) ? S_NEXT : S_FILL;
                    end
                end
                S_FILL: begin
                    fill_cnt <= fill_cnt + 1'b1;
                    if (fill_cnt == size_q - 1'b1) st <= S_NEXT;
                end
                S_NEXT: begin
                    hcnt <= '0;
                    st   <= (idx >= psz) ? S_DONE : S_HRD;
                end
                S_HRD: begin
                    st <= (hpos >= psz) ? S_DONE : S_HCAP;
                end
                S_HCAP: begin
                    if (phy_rd_data == ERASED) begin
                        st <= S_DONE;
                    end else if (hcnt == hlast) begin
                        st <= S_HEVAL;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                        st   <= S_HRD;
                    end
                end
                S_HEVAL: begin
                    idx  <= idx + IW'(hlast) + 1'b1;
                    widx <= '0;
                    if (hdr.blk >= 13'(MAX_BLK)) begin
                        err_q <= 1'b1;
                        st    <= S_DONE;
                    end else begin
                        st <= S_WORD;
                    end
                end
                S_WORD: begin
                    if (widx[2]) begin
                        st <= S_NEXT;
                    end else if (hdr.wen[widx[1:0]]) begin
                        widx <= widx + 1'b1;
                    end else if ((idx + 1'b1) >= psz) begin
                        err_q <= 1'b1;
                        st    <= S_DONE;
                    end else if (page_ok && in_win) begin
                        st <= S_W0RD;
                    end else begin
                        idx  <= idx + 2'd2;
                        widx <= widx + 1'b1;
                    end
                end
                S_W0RD:  st <= S_W0CAP;
                S_W0CAP: begin
                    b0 <= phy_rd_data;
                    st <= S_W1RD;
                end
                S_W1RD:  st <= S_W1CAP;
                S_W1CAP: begin
                    b1 <= phy_rd_data;
                    st <= wr_lo ? S_WLO : S_WHI;
                end
                S_WLO: begin
                    if (wr_hi) begin
                        st <= S_WHI;
                    end else begin
                        idx  <= idx + 2'd2;
                        widx <= widx + 1'b1;
                        st   <= S_WORD;
                    end
                end
                S_WHI: begin
                    idx  <= idx + 2'd2;
                    widx <= widx + 1'b1;
                    st   <= S_WORD;
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Checks on the running parse
    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        log_wr_en |-> ({1'b0, log_wr_addr} < size_q)); // R6

    AST_RD_IN_IMAGE: assert property (@(posedge clk) disable iff (rst)
        phy_rd_en |-> ({2'b00, phy_rd_addr} < psz)); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE && start) |=> ($stable(off_q) && $stable(size_q) && $stable(psz))); // R13

    AST_NO_RD_AND_WR: assert property (@(posedge clk) disable iff (rst)
        !(phy_rd_en && log_wr_en)); // R2

endmodule

// File: tb/fuse_map_parser_test.sv
module fuse_map_parser_test;

    localparam int PAW = 10;
    localparam int MLB = 1024;
    localparam int LAW = 10;
    localparam int LW  = 11;
    localparam int MAXB = MLB / 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst, start, cfg_alt;
    logic [2:0]     cfg_page;
    logic [LW-1:0]  cfg_off, cfg_size;
    logic [PAW-1:0] cfg_skip;
    logic [PAW:0]   cfg_psz;
    logic           rd_en;
    logic [PAW-1:0] rd_addr;
    logic [7:0]     rd_data;
    logic           wr_en;
    logic [LAW-1:0] wr_addr;
    logic [7:0]     wr_data;
    logic           done, err;

    fuse_map_parser #(.PHY_AW(PAW), .MAX_LOG_BYTES(MLB)) uut (
        .clk(clk), .rst(rst), .start(start), .cfg_alt(cfg_alt), .cfg_page(cfg_page),
        .cfg_offset(cfg_off), .cfg_size(cfg_size), .cfg_skip(cfg_skip),
        .cfg_phy_size(cfg_psz), .phy_rd_en(rd_en), .phy_rd_addr(rd_addr),
        .phy_rd_data(rd_data), .log_wr_en(wr_en), .log_wr_addr(wr_addr),
        .log_wr_data(wr_data), .done(done), .err(err)
    );

    logic [7:0] pmem [0:1023];
    logic [7:0] lmap [0:1023];
    logic [7:0] emap [0:1023];
    int eq_a[$];
    int eq_d[$];
    bit exp_err;
    int checks = 0;
    int errors = 0;
    int wp;
    string cur_tag = "R1";

    always @(posedge clk) if (rd_en) rd_data <= pmem[rd_addr];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Every write is compared with the predicted write order as it happens
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            lmap[wr_addr] = wr_data;
            if (eq_a.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected write addr", int'(wr_addr), -1);
            end else begin
                chk(int'(wr_addr) == eq_a[0], cur_tag, "write addr", int'(wr_addr), eq_a[0]);
                chk(int'(wr_data) == eq_d[0], cur_tag, "write data", int'(wr_data), eq_d[0]);
                void'(eq_a.pop_front());
                void'(eq_d.pop_front());
            end
        end
    end

    task automatic put(input int v);
        pmem[wp] = v[7:0];
        wp++;
    endtask

    task automatic hdr_n(input int page, input int blk, input int mask);
        int h;
        h = (page << 17) | (blk << 4) | mask;
        put(h >> 16); put(h >> 8); put(h);
    endtask

    task automatic hdr_a(input int blk, input int mask);
        int h;
        h = (blk << 4) | mask;
        put(h >> 8); put(h);
    endtask

    task automatic words(input int n, input int base);
        for (int k = 0; k < 2 * n; k++) put(base + k);
    endtask

    task automatic clear_image();
        for (int k = 0; k < 1024; k++) pmem[k] = 8'hFF;
        wp = 0;
    endtask

    task automatic push_wr(input int a, input int d);
        eq_a.push_back(a);
        eq_d.push_back(d);
        emap[a] = d[7:0];
    endtask

    // Behavioural reference of the whole parse
    task automatic model(input bit alt, input int page, input int off, input int size,
                         input int skip, input int psz);
        int idx, hl, h, pg, blk, msk, li, wmin, wmax, fin;
        bit stop;
        eq_a.delete(); eq_d.delete();
        exp_err = 1'b0;
        for (int a = 0; a < size; a++) push_wr(a, 8'hFF);
        wmin = off - (off % 2);
        fin  = off + size;
        wmax = fin + (fin % 2);
        idx  = skip;
        stop = 1'b0;
        hl   = alt ? 2 : 3;
        while (!stop && idx < psz) begin
            h = 0;
            for (int k = 0; k < hl; k++) begin
                if (!stop) begin
                    if (idx + k >= psz || pmem[idx + k] == 8'hFF) stop = 1'b1;
                    else h = (h << 8) | pmem[idx + k];
                end
            end
            if (!stop) begin
                idx += hl;
                msk = h & 15;
                if (alt) begin pg = page; blk = (h >> 4) & 255; end
                else begin pg = (h >> 17) & 7; blk = (h >> 4) & 8191; end
                if (blk >= MAXB) begin
                    exp_err = 1'b1; stop = 1'b1;
                end
                for (int i = 0; i < 4; i++) begin
                    if (!stop && !msk[i]) begin
                        if (idx >= psz - 1) begin
                            exp_err = 1'b1; stop = 1'b1;
                        end else begin
                            li = blk * 8 + i * 2;
                            if (pg == page && li >= wmin && li < wmax) begin
                                if (!(li == wmin && off > wmin)) push_wr(li - off, pmem[idx]);
                                if (!(li + 2 == wmax && fin < wmax)) push_wr(li - off + 1, pmem[idx + 1]);
                            end
                            idx += 2;
                        end
                    end
                end
            end
        end
    endtask

    task automatic run(input string tag, input bit alt, input int page, input int off,
                       input int size, input int skip, input int psz, input bit poke);
        int cyc;
        cur_tag = tag;
        for (int k = 0; k < 1024; k++) begin lmap[k] = 8'h00; emap[k] = 8'h00; end
        model(alt, page, off, size, skip, psz);
        @(negedge clk);
        cfg_alt = alt; cfg_page = page[2:0]; cfg_off = off[LW-1:0]; cfg_size = size[LW-1:0];
        cfg_skip = skip[PAW-1:0]; cfg_psz = psz[PAW:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 30) begin
                cfg_off = 0; cfg_size = 2; cfg_psz = 0; cfg_alt = ~alt;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                cyc++;
            end
        end
        chk(cyc < 20000, tag, "watchdog, done seen", 0, 1);
        chk(err == exp_err, tag, "err flag", int'(err), int'(exp_err));
        chk(eq_a.size() == 0, tag, "writes left over", eq_a.size(), 0);
        for (int k = 0; k < size; k++)
            chk(lmap[k] == emap[k], tag, $sformatf("map byte %0d", k), int'(lmap[k]), int'(emap[k]));
        @(negedge clk);
        chk(!done, tag, "done single cycle", int'(done), 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; cfg_alt = 1'b0; cfg_page = '0; cfg_off = '0;
        cfg_size = '0; cfg_skip = '0; cfg_psz = '0;
        clear_image();
        repeat (3) @(negedge clk);
        chk(!done && !err && !rd_en && !wr_en, "R1", "outputs in reset", {done, err, rd_en, wr_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !err && !rd_en && !wr_en, "R1", "outputs after reset", {done, err, rd_en, wr_en}, 0);

        // R3 R5 R7 R12: mixed masks, foreign page, repeated block
        clear_image();
        wp = 4;
        hdr_n(1, 0, 4'b0000);  words(4, 8'h10);
        hdr_n(1, 1, 4'b1010);  words(2, 8'h20);
        hdr_n(2, 0, 4'b0000);  words(4, 8'h30);
        hdr_n(1, 1, 4'b1110);  words(1, 8'h40);
        hdr_n(1, 0, 4'b0111);  words(1, 8'h50);
        run("R3_R5_R7_R12", 1'b0, 1, 0, 16, 4, 64, 1'b0);
        // R2 R11: skip region ignored, bytes never reached stay 0xFF
        run("R2_R11", 1'b0, 1, 16, 8, 4, 64, 1'b0);
        // R6: odd window edges on same image
        run("R6", 1'b0, 1, 3, 6, 4, 64, 1'b0);
        run("R6_single", 1'b0, 1, 5, 1, 4, 64, 1'b0);
        // R13: start while busy
        run("R13", 1'b0, 1, 0, 16, 4, 64, 1'b1);
        // R7: page 2 window sees only foreign record
        run("R7", 1'b0, 2, 0, 8, 4, 64, 1'b0);

        // R4: compact headers
        clear_image();
        hdr_a(1, 4'b0000);   words(4, 8'h60);
        hdr_a(2, 4'b0101);   words(2, 8'h70);
        hdr_a(1, 4'b1101);   words(1, 8'h80);
        run("R4", 1'b1, 5, 8, 12, 0, 40, 1'b0);

        // R9: block offset overflow after a good record
        clear_image();
        hdr_n(0, 0, 4'b1100); words(2, 8'h90);
        hdr_n(0, 200, 4'b0000); words(4, 8'hA0);
        run("R9", 1'b0, 0, 0, 8, 0, 64, 1'b0);

        // R10: truncated word
        clear_image();
        hdr_n(0, 0, 4'b0000); words(4, 8'hB0);
        run("R10", 1'b0, 0, 0, 8, 0, 8, 1'b0);

        // R8: end by image length, header straddling end, skip beyond image
        run("R8_len", 1'b0, 0, 0, 8, 0, 11, 1'b0);
        pmem[11] = 8'h00;
        run("R8_straddle", 1'b0, 0, 0, 8, 0, 12, 1'b0);
        run("R8_R11_skip", 1'b0, 0, 0, 4, 20, 12, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule